// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block is the command engine of a small SDRAM controller. After reset it waits a parameterised settling time with the clock enable high. It then closes every bank, performs a fixed number of auto-refresh cycles, and writes a configuration word into the device mode register. Only after these steps does it raise `ready`. From then on it accepts one access at a time on a valid/acknowledge port. Each access opens a row, issues a single read or write with auto-precharge, and holds off further commands until the row cycle is complete.

A free-running interval counter raises a refresh request every `REF_INTERVAL` clocks once the block is ready. An outstanding refresh is served at the next idle point, ahead of any waiting access. All timing limits are parameters counted in clocks. Command pins are registered, so every command is visible for exactly one clock, and NOP is shown on the pins otherwise.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: While `rst_n` is low, `sdrCke` is low, the pins show NOP, and `ready` and `reqAck` are low.
- R2: The first command after reset release is PRECHARGE with `sdrAddr` = 12'h400 (bit 10 set: all banks). It appears exactly `INIT_CYC` clocks after the cycle in which reset is released, preceded only by NOPs with `sdrCke` high.
- R3: After that PRECHARGE come exactly `INIT_REFS` (2) AUTO REFRESH commands, then LOAD MODE. The first AUTO REFRESH is `T_RP` clocks after the PRECHARGE. The second AUTO REFRESH is `T_RC` clocks after the first, and LOAD MODE is `T_RC` clocks after the second. LOAD MODE carries `sdrAddr` = `MODE_WORD` and `sdrBa` = 0.
- R4: `ready` rises `T_MRD`−1 clocks after LOAD MODE appears on the pins, and never falls again before the next reset.
- R5: Pin encodings {CS#,RAS#,CAS#,WE#} are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R6: `reqAddr` is {bank[22:21], row[20:9], column[8:0]}. An accepted request gives a one-clock `reqAck` pulse while `reqValid` is high. ACTIVE follows on the next clock with `sdrBa` = bank and `sdrAddr` = row.
- R7: READ (`reqWrite`=0) or WRITE (`reqWrite`=1) appears exactly `T_RCD` clocks after ACTIVE, with NOPs between. It carries the same bank and `sdrAddr` = {0, 1 at bit 10, 0 at bit 9, column}, so auto-precharge is always requested.
- R8: After READ/WRITE the pins show NOP for `RW_HOLD`−1 clocks, where `RW_HOLD` = max(`T_RC`−`T_RCD`, `T_BURST`+`T_RP`). Two ACTIVE commands are therefore never closer than `T_RCD`+`RW_HOLD`.
- R9: Once ready, a refresh falls due every `REF_INTERVAL` clocks. While the port is idle, consecutive AUTO REFRESH commands are exactly `REF_INTERVAL` clocks apart.
- R10: When a refresh is due in the same idle clock as a valid request, AUTO REFRESH is issued first. The request is acknowledged `T_RC`−1 clocks after that AUTO REFRESH appears, and its ACTIVE appears `T_RC` clocks after it.
- R11: No request is acknowledged before `ready` is high. A request held from reset is acknowledged in the first clock that `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request pending |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 23 | {bank, row, column} of the access |
| reqAck | output | 1 | One-clock acceptance pulse |
| ready | output | 1 | Initialisation complete |
| sdrCke | output | 1 | Clock enable to the memory |
| sdrCsN | output | 1 | Chip select, active low |
| sdrRasN | output | 1 | Row strobe, active low |
| sdrCasN | output | 1 | Column strobe, active low |
| sdrWeN | output | 1 | Write enable, active low |
| sdrBa | output | 2 | Bank select |
| sdrAddr | output | 12 | Multiplexed row/column/mode address |

## Verification
The hardest case to reach is a refresh falling due in the very idle clock in which a request is also waiting. The refresh counter is internal and runs freely, so this clock cannot be set directly. The stimulus first leaves the port idle through three refreshes, so that the refresh schedule is known exactly from the pins. It then raises `reqValid` in the clock just before the next refresh appears, and checks that the refresh wins and the acknowledge is delayed by the row cycle. A request is also held asserted through the whole power-up sequence, to show that it is first accepted in the first ready clock.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

  parameter int WAIT_W = 16;

  typedef enum logic [3:0] {
    CMD_LOADMODE  = 4'b0000,
    CMD_REFRESH   = 4'b0001,
    CMD_PRECHARGE = 4'b0010,
    CMD_ACTIVE    = 4'b0011,
    CMD_WRITE     = 4'b0100,
    CMD_READ      = 4'b0101,
    CMD_NOP       = 4'b0111
  } sdrCmd_e;

  typedef enum logic [2:0] {
    ASEL_ZERO,
    ASEL_ALLBANK,
    ASEL_ROW,
    ASEL_COL,
    ASEL_MODE
  } addrSel_e;

  typedef struct packed {
    logic              issue;
    sdrCmd_e           cmd;
    addrSel_e          addrSel;
    logic              loadWait;
    logic [WAIT_W-1:0] waitVal;
    logic              latchReq;
    logic              refServed;
    logic              setReady;
  } seqStrobe_t;

endpackage

// File: rtl/sdr_seq_ctrl.sv
module sdr_seq_ctrl
  import sdr_seq_pkg::*;
#(
  parameter int T_RP      = 4,
  parameter int T_RC      = 13,
  parameter int T_RCD     = 4,
  parameter int T_MRD     = 2,
  parameter int RW_HOLD   = 8,
  parameter int INIT_REFS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic       waitZero,
  input  logic       refPending,
  input  logic       ready,
  input  logic       latWrite,
  output seqStrobe_t stb,
  output logic       reqAck
);

  localparam int IREF_W = $clog2(INIT_REFS + 1);

  typedef enum logic [3:0] {
    ST_INIT, ST_PALL, ST_PALL_W, ST_IREF, ST_IREF_W, ST_MODE, ST_MODE_W,
    ST_IDLE, ST_REF_W, ST_ACT_W, ST_RW, ST_RW_W
  } seqState_e;

  seqState_e state, nxt;
  logic [IREF_W-1:0] irefCnt;
  logic irefDone;

  assign irefDone = (irefCnt == IREF_W'(INIT_REFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_INIT;
      irefCnt <= '0;
    end else begin
      state <= nxt;
      if (state == ST_IREF) irefCnt <= irefCnt + 1'b1;
    end
  end

  always_comb begin
    nxt         = state;
    stb         = '0;
    stb.cmd     = CMD_NOP;
    stb.addrSel = ASEL_ZERO;
    reqAck      = 1'b0;
    case (state)
      ST_INIT:   if (waitZero) nxt = ST_PALL;
      ST_PALL: begin
        stb.issue = 1'b1; stb.cmd = CMD_PRECHARGE; stb.addrSel = ASEL_ALLBANK;
        stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(T_RP - 2);
        nxt = ST_PALL_W;
      end
      ST_PALL_W: if (waitZero) nxt = ST_IREF;
      ST_IREF: begin
        stb.issue = 1'b1; stb.cmd = CMD_REFRESH;
        stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(T_RC - 2);
        nxt = ST_IREF_W;
      end
      ST_IREF_W: if (waitZero) nxt = irefDone ? ST_MODE : ST_IREF;
      ST_MODE: begin
        stb.issue = 1'b1; stb.cmd = CMD_LOADMODE; stb.addrSel = ASEL_MODE;
        stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(T_MRD - 2);
        nxt = ST_MODE_W;
      end
      ST_MODE_W: if (waitZero) begin
        stb.setReady = 1'b1;
        nxt = ST_IDLE;
      end
      ST_IDLE: begin
        if (refPending) begin
          stb.issue = 1'b1; stb.cmd = CMD_REFRESH; stb.refServed = 1'b1;
          stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(T_RC - 2);
          nxt = ST_REF_W;
        end else if (reqValid) begin
          stb.issue = 1'b1; stb.cmd = CMD_ACTIVE; stb.addrSel = ASEL_ROW;
          stb.latchReq = 1'b1; reqAck = 1'b1;
          stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(T_RCD - 2);
          nxt = ST_ACT_W;
        end
      end
      ST_REF_W:  if (waitZero) nxt = ST_IDLE;
      ST_ACT_W:  if (waitZero) nxt = ST_RW;
      ST_RW: begin
        stb.issue = 1'b1; stb.cmd = latWrite ? CMD_WRITE : CMD_READ;
        stb.addrSel = ASEL_COL;
        stb.loadWait = 1'b1; stb.waitVal = WAIT_W'(RW_HOLD - 2);
        nxt = ST_RW_W;
      end
      ST_RW_W:   if (waitZero) nxt = ST_IDLE;
      default:   nxt = ST_INIT;
    endcase
  end

  // R11
  ack_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |-> ready);

  // R6
  ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reqAck |-> reqValid);

endmodule

// File: rtl/sdr_seq_dp.sv
module sdr_seq_dp
  import sdr_seq_pkg::*;
#(
  parameter int              INIT_CYC     = 20000,
  parameter int              REF_INTERVAL = 3000,
  parameter int              ROW_W        = 12,
  parameter int              COL_W        = 9,
  parameter int              BANK_W       = 2,
  parameter logic [ROW_W-1:0] MODE_WORD   = 12'h032,
  localparam int             REQ_W        = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        stb,
  input  logic              reqWrite,
  input  logic [REQ_W-1:0]  reqAddr,
  output logic              waitZero,
  output logic              refPending,
  output logic              ready,
  output logic              latWrite,
  output logic [3:0]        cmdOut,
  output logic [BANK_W-1:0] baOut,
  output logic [ROW_W-1:0]  addrOut,
  output logic              ckeOut
);

  localparam int AP_BIT = 10;
  localparam int REF_W  = $clog2(REF_INTERVAL);

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic              refTick;
  logic [BANK_W-1:0] latBank;
  logic [COL_W-1:0]  latCol;
  logic [ROW_W-1:0]  addrNext;
  logic [BANK_W-1:0] baNext;
  sdrCmd_e           cmdReg;

  // single wait timer shared by all command spacings
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                waitCnt <= WAIT_W'(INIT_CYC - 2);
    else if (stb.loadWait)     waitCnt <= stb.waitVal;
    else if (waitCnt != '0)    waitCnt <= waitCnt - 1'b1;
  end
  assign waitZero = (waitCnt == '0);

  // refresh interval counter, runs only once initialised
  assign refTick = ready && (refCnt == REF_W'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else begin
      if (ready) refCnt <= refTick ? '0 : refCnt + 1'b1;
      if (refTick)            refPending <= 1'b1;
      else if (stb.refServed) refPending <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready    <= 1'b0;
      ckeOut   <= 1'b0;
      latBank  <= '0;
      latCol   <= '0;
      latWrite <= 1'b0;
    end else begin
      ckeOut <= 1'b1;
      if (stb.setReady) ready <= 1'b1;
      if (stb.latchReq) begin
        latBank  <= reqAddr[REQ_W-1 -: BANK_W];
        latCol   <= reqAddr[COL_W-1:0];
        latWrite <= reqWrite;
      end
    end
  end

  always_comb begin
    addrNext = '0;
    baNext   = '0;
    case (stb.addrSel)
      ASEL_ALLBANK: addrNext[AP_BIT] = 1'b1;
      ASEL_ROW: begin
        addrNext = reqAddr[COL_W +: ROW_W];
        baNext   = reqAddr[REQ_W-1 -: BANK_W];
      end
      ASEL_COL: begin
        addrNext[COL_W-1:0] = latCol;
        addrNext[AP_BIT]    = 1'b1;
        baNext              = latBank;
      end
      ASEL_MODE: addrNext = MODE_WORD;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdReg  <= CMD_NOP;
      addrOut <= '0;
      baOut   <= '0;
    end else begin
      cmdReg  <= stb.issue ? stb.cmd : CMD_NOP;
      addrOut <= stb.issue ? addrNext : '0;
      baOut   <= stb.issue ? baNext : '0;
    end
  end
  assign cmdOut = cmdReg;

  // R4
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

  // R9
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(refPending) |-> $past(stb.refServed));

  // R7
  rw_autoprecharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReg == CMD_READ || cmdReg == CMD_WRITE) |-> addrOut[AP_BIT]);

  // R3
  mode_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReg == CMD_LOADMODE) |-> (addrOut == MODE_WORD && baOut == '0));

  // R2
  precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdReg == CMD_PRECHARGE) |-> addrOut[AP_BIT]);

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
  import sdr_seq_pkg::*;
#(
  parameter int               INIT_CYC     = 20000,
  parameter int               REF_INTERVAL = 3000,
  parameter int               T_RP         = 4,
  parameter int               T_RC         = 13,
  parameter int               T_RCD        = 4,
  parameter int               T_MRD        = 2,
  parameter int               T_BURST      = 4,
  parameter int               INIT_REFS    = 2,
  parameter int               ROW_W        = 12,
  parameter int               COL_W        = 9,
  parameter int               BANK_W       = 2,
  parameter logic [ROW_W-1:0] MODE_WORD    = 12'h032,
  localparam int              REQ_W        = BANK_W + ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [REQ_W-1:0]  reqAddr,
  output logic              reqAck,
  output logic              ready,
  output logic              sdrCke,
  output logic              sdrCsN,
  output logic              sdrRasN,
  output logic              sdrCasN,
  output logic              sdrWeN,
  output logic [BANK_W-1:0] sdrBa,
  output logic [ROW_W-1:0]  sdrAddr
);

  localparam int RC_LEFT = T_RC - T_RCD;
  localparam int PRE_END = T_BURST + T_RP;
  localparam int RW_HOLD = (RC_LEFT > PRE_END) ? RC_LEFT : PRE_END;

  seqStrobe_t stb;
  logic       waitZero, refPending, latWrite;
  logic [3:0] cmdOut;

  sdr_seq_ctrl #(
    .T_RP(T_RP), .T_RC(T_RC), .T_RCD(T_RCD), .T_MRD(T_MRD),
    .RW_HOLD(RW_HOLD), .INIT_REFS(INIT_REFS)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .waitZero(waitZero),
    .refPending(refPending), .ready(ready), .latWrite(latWrite),
    .stb(stb), .reqAck(reqAck)
  );

  sdr_seq_dp #(
    .INIT_CYC(INIT_CYC), .REF_INTERVAL(REF_INTERVAL), .ROW_W(ROW_W),
    .COL_W(COL_W), .BANK_W(BANK_W), .MODE_WORD(MODE_WORD)
  ) i_dp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .waitZero(waitZero), .refPending(refPending), .ready(ready),
    .latWrite(latWrite), .cmdOut(cmdOut), .baOut(sdrBa), .addrOut(sdrAddr),
    .ckeOut(sdrCke)
  );

  assign {sdrCsN, sdrRasN, sdrCasN, sdrWeN} = cmdOut;

endmodule

// File: tb/test_sdr_init_refresh_seq.sv
`timescale 1ns/1ps
module test_sdr_init_refresh_seq;

  localparam int INIT_CYC = 12;
  localparam int REF_INT  = 200;
  localparam int TRP = 3, TRC = 6, TRCD = 3, TMRD = 2, TBURST = 4;
  localparam logic [11:0] MODEW = 12'h032;
  localparam int RWHOLD = (TRC - TRCD > TBURST + TRP) ? TRC - TRCD : TBURST + TRP;
  localparam int ACTGAP = TRCD + RWHOLD;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
    C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

  // {write, bank, row, column}
  localparam logic [23:0] VEC [4] = '{
    {1'b0, 2'd1, 12'hABC, 9'h155},
    {1'b1, 2'd3, 12'hFFF, 9'h1FF},
    {1'b0, 2'd0, 12'h000, 9'h000},
    {1'b1, 2'd2, 12'h800, 9'h0AA}
  };

  logic clk = 1'b0, rst_n = 1'b0, reqValid = 1'b0, reqWrite = 1'b0;
  logic [22:0] reqAddr = '0;
  logic reqAck, ready, sdrCke, sdrCsN, sdrRasN, sdrCasN, sdrWeN;
  logic [1:0] sdrBa;
  logic [11:0] sdrAddr;
  logic [3:0] pinCmd;
  int cyc = 0, checks = 0, errors = 0, prevAct = -1;
  bit finished = 0;

  assign pinCmd = {sdrCsN, sdrRasN, sdrCasN, sdrWeN};

  sdr_init_refresh_seq #(
    .INIT_CYC(INIT_CYC), .REF_INTERVAL(REF_INT), .T_RP(TRP), .T_RC(TRC),
    .T_RCD(TRCD), .T_MRD(TMRD), .T_BURST(TBURST), .MODE_WORD(MODEW)
  ) i_sdr_init_refresh_seq (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqAck(reqAck), .ready(ready), .sdrCke(sdrCke),
    .sdrCsN(sdrCsN), .sdrRasN(sdrRasN), .sdrCasN(sdrCasN), .sdrWeN(sdrWeN),
    .sdrBa(sdrBa), .sdrAddr(sdrAddr)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic waitCmd(input logic [3:0] c, output int at);
    int guard = 0;
    while (pinCmd != c && guard < 3000) begin step(); guard++; end
    chk(guard < 3000, "R9 command seen in time", guard, 3000);
    at = cyc;
  endtask

  // runs from the acknowledge clock onward
  task automatic finishReq(input logic w, input logic [1:0] b,
                           input logic [11:0] r, input logic [8:0] c);
    step();
    reqValid = 1'b0;
    chk(!reqAck, "R6 single ack pulse", reqAck, 0);
    chk(pinCmd == C_ACT, "R6 ACTIVE follows ack", pinCmd, C_ACT);
    chk(sdrBa == b, "R6 ACTIVE bank", sdrBa, b);
    chk(sdrAddr == r, "R6 ACTIVE row", sdrAddr, r);
    if (prevAct >= 0)
      chk(cyc - prevAct >= ACTGAP, "R8 ACTIVE spacing", cyc - prevAct, ACTGAP);
    prevAct = cyc;
    for (int k = 1; k < TRCD; k++) begin
      step();
      chk(pinCmd == C_NOP, "R7 NOP before column command", pinCmd, C_NOP);
    end
    step();
    chk(pinCmd == (w ? C_WR : C_RD), "R7 READ/WRITE after tRCD", pinCmd, w ? C_WR : C_RD);
    chk(sdrBa == b, "R7 column bank", sdrBa, b);
    chk(sdrAddr == (12'h400 | {3'b000, c}), "R7 column with auto-precharge",
        sdrAddr, 12'h400 | {3'b000, c});
    for (int k = 1; k < RWHOLD; k++) begin
      step();
      chk(pinCmd == C_NOP, "R8 NOP during row cycle", pinCmd, C_NOP);
    end
  endtask

  task automatic doReq(input logic w, input logic [1:0] b,
                       input logic [11:0] r, input logic [8:0] c);
    int guard = 0;
    reqWrite = w; reqAddr = {b, r, c}; reqValid = 1'b1;
    #1;
    while (!reqAck && guard < 3000) begin step(); guard++; end
    chk(guard < 3000, "R6 request acknowledged", guard, 3000);
    finishReq(w, b, r, c);
  endtask

  initial begin
    int relCyc, readyCyc, n, r1, r2, r3, refCyc, ackCyc, guard;
    logic [3:0] seqCmd [4];
    int seqCyc [4];
    logic [11:0] seqAddr [4];
    logic [1:0] seqBa [4];
    bit ackEarly, ckeLow;

    // R1 and R11: reset held with a request already waiting
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = {2'd2, 12'h123, 9'h045};
    for (int k = 0; k < 5; k++) begin
      step();
      chk(!sdrCke, "R1 CKE low in reset", sdrCke, 0);
      chk(pinCmd == C_NOP, "R1 NOP in reset", pinCmd, C_NOP);
      chk(!ready, "R1 ready low in reset", ready, 0);
      chk(!reqAck, "R1 no ack in reset", reqAck, 0);
    end
    rst_n = 1'b1;
    relCyc = cyc;
    n = 0; ackEarly = 0; ckeLow = 0; guard = 0;
    while (!ready && guard < 1000) begin
      step(); guard++;
      if (reqAck && !ready) ackEarly = 1;
      if (!sdrCke) ckeLow = 1;
      if (pinCmd != C_NOP && n < 4) begin
        seqCmd[n] = pinCmd; seqCyc[n] = cyc; seqAddr[n] = sdrAddr; seqBa[n] = sdrBa; n++;
      end
    end
    readyCyc = cyc;
    chk(!ackEarly, "R11 no ack before ready", ackEarly, 0);
    chk(!ckeLow, "R2 CKE high after reset", ckeLow, 0);
    chk(n == 4, "R3 four init commands", n, 4);
    chk(seqCmd[0] == C_PRE, "R2 first command PRECHARGE", seqCmd[0], C_PRE);
    chk(seqAddr[0] == 12'h400, "R2 precharge all banks", seqAddr[0], 12'h400);
    chk(seqCyc[0] - relCyc == INIT_CYC, "R2 power-up wait", seqCyc[0] - relCyc, INIT_CYC);
    chk(seqCmd[1] == C_REF, "R3 first init refresh", seqCmd[1], C_REF);
    chk(seqCyc[1] - seqCyc[0] == TRP, "R3 tRP after precharge", seqCyc[1] - seqCyc[0], TRP);
    chk(seqCmd[2] == C_REF, "R3 second init refresh", seqCmd[2], C_REF);
    chk(seqCyc[2] - seqCyc[1] == TRC, "R3 tRC between refreshes", seqCyc[2] - seqCyc[1], TRC);
    chk(seqCmd[3] == C_MRS, "R5 LOAD MODE encoding", seqCmd[3], C_MRS);
    chk(seqCyc[3] - seqCyc[2] == TRC, "R3 tRC before LOAD MODE", seqCyc[3] - seqCyc[2], TRC);
    chk(seqAddr[3] == MODEW, "R3 mode word", seqAddr[3], MODEW);
    chk(seqBa[3] == 2'd0, "R3 mode bank zero", seqBa[3], 0);
    chk(readyCyc - seqCyc[3] == TMRD - 1, "R4 ready after tMRD", readyCyc - seqCyc[3], TMRD - 1);
    chk(reqAck, "R11 held request acked on first ready clock", reqAck, 1);
    finishReq(1'b0, 2'd2, 12'h123, 9'h045);

    // table of accesses, issued back to back
    for (int i = 0; i < 4; i++)
      doReq(VEC[i][23], VEC[i][22:21], VEC[i][20:9], VEC[i][8:0]);
    chk(ready, "R4 ready stays high", ready, 1);

    // R9: idle refresh period
    waitCmd(C_REF, r1); step();
    waitCmd(C_REF, r2); step();
    waitCmd(C_REF, r3);
    chk(r3 - r2 == REF_INT, "R9 idle refresh period", r3 - r2, REF_INT);
    chk(ready, "R4 ready stays high after refreshes", ready, 1);

    // R10: request raised in the clock the next refresh falls due
    while (cyc < r3 + REF_INT - 1) step();
    reqWrite = 1'b1; reqAddr = {2'd1, 12'h5A5, 9'h0F0}; reqValid = 1'b1;
    #1;
    chk(!reqAck, "R10 no ack while refresh due", reqAck, 0);
    step();
    chk(pinCmd == C_REF, "R10 refresh issued first", pinCmd, C_REF);
    refCyc = cyc;
    chk(refCyc - r3 == REF_INT, "R9 refresh period kept", refCyc - r3, REF_INT);
    guard = 0;
    while (!reqAck && guard < 100) begin
      chk(pinCmd == C_NOP || cyc == refCyc, "R10 NOP during refresh", pinCmd, C_NOP);
      step(); guard++;
    end
    ackCyc = cyc;
    chk(ackCyc - refCyc == TRC - 1, "R10 ack after refresh tRC", ackCyc - refCyc, TRC - 1);
    finishReq(1'b1, 2'd1, 12'h5A5, 9'h0F0);
    chk(prevAct - refCyc == TRC, "R10 ACTIVE tRC after refresh", prevAct - refCyc, TRC);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule